// File: doc/BRIEF.md
# Cascadable Four-Bit ALU Slice

This block is a purely combinational arithmetic logic unit slice. It works on two operands of four bits each, a three-bit mode select and a carry input. It drives a four-bit result, a carry output and a two's-complement overflow flag. Three modes are arithmetic: addition, A minus B and B minus A. Three modes are bitwise logic operations. Two modes drive a constant result.

Wider datapaths are built by ripple chaining. Each slice's carry output feeds the carry input of the next more significant slice. The subtract modes need the carry input of the least significant slice held high. The slice never inserts that carry itself, so with the carry input low a subtraction yields the difference minus one.

Top module: `alu4_ripple_slice`

## Requirements
- R1: The mode select picks the operation by code: 0 clear, 1 B minus A, 2 A minus B, 3 A plus B, 4 A XOR B, 5 A OR B, 6 A AND B, 7 preset.
- R2: In mode 0 the result is all zeros, and in mode 7 it is all ones, whatever the operands and carry input are.
- R3: In mode 3, {carry_out, result} equals op_a + op_b + carry_in, so a high carry input increments the sum.
- R4: In mode 2, {carry_out, result} equals op_a + ~op_b + carry_in. In mode 1 it equals ~op_a + op_b + carry_in. With carry_in high these give the true differences A-B and B-A, and with carry_in low each gives the difference minus one.
- R5: In the three arithmetic modes, overflow is high exactly when the carry into the top bit differs from the carry out of the top bit. This is the case exactly when the signed result is out of range for the signed operands the adder sees.
- R6: In modes 0, 4, 5, 6 and 7 the carry output and the overflow output are both low, and the result is bitwise with no carry propagation.
- R7: Four slices chained carry_out to carry_in form a 16-bit unit. Its add and subtract results, final carry and top-slice overflow match 16-bit arithmetic.
- R8: The outputs depend only on the present inputs, with no storage for any mode code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | Operand A |
| op_b | input | 4 | Operand B |
| mode_sel | input | 3 | Operation select code |
| carry_in | input | 1 | Carry into bit 0 |
| result | output | 4 | Function result |
| carry_out | output | 1 | Carry out of the top bit, for ripple chaining |
| overflow | output | 1 | Two's-complement overflow flag |

## Verification
The slice holds no state. A wrong internal value, such as an operand complemented on the wrong side, a broken carry link or a mis-decoded mode, shows on result, carry_out or overflow as soon as the inputs settle, for the affected input pattern. The bench walks every input combination against its own integer model, so each such fault appears on the first pattern that needs the faulty path. The internal carries are not exposed at the ports. For that reason a carry fault in the top bit is also checked through the overflow flag and through the 16-bit chain, where a wrong carry out of one slice corrupts every more significant result nibble.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    MODE_CLEAR  = 3'd0,
    MODE_B_SUBA = 3'd1,
    MODE_A_SUBB = 3'd2,
    MODE_ADD    = 3'd3,
    MODE_XOR    = 3'd4,
    MODE_OR     = 3'd5,
    MODE_AND    = 3'd6,
    MODE_PRESET = 3'd7
  } alu_mode_e;

  // True for the three modes that use the adder and drive the flags.
  function automatic logic mode_is_arith(input alu_mode_e m);
    return (m == MODE_ADD) || (m == MODE_A_SUBB) || (m == MODE_B_SUBA);
  endfunction

  // One full-adder cell: returns {carry, sum}.
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic c);
    return {(x & y) | (x & c) | (y & c), x ^ y ^ c};
  endfunction

  // Overflow seen as a sign rule: equal operand signs, different result sign.
  function automatic logic sign_overflow(input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  alu_mode_e        mode,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] x_out,
  output logic [WIDTH-1:0] y_out
);

  // Subtraction is done by inverting one operand ahead of the shared adder.
  always_comb begin
    x_out = a_in;
    y_out = b_in;
    unique case (mode)
      MODE_A_SUBB: y_out = ~b_in;
      MODE_B_SUBA: x_out = ~a_in;
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH:0]   carry
);

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic [1:0] cs;
    assign cs           = full_add(x[i], y[i], carry[i]);
    assign sum[i]       = cs[0];
    assign carry[i + 1] = cs[1];
  end

endmodule

// File: rtl/alu_bitwise_unit.sv
module alu_bitwise_unit
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  alu_mode_e        mode,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] logic_out
);

  always_comb begin
    unique case (mode)
      MODE_XOR:    logic_out = a_in ^ b_in;
      MODE_OR:     logic_out = a_in | b_in;
      MODE_AND:    logic_out = a_in & b_in;
      MODE_PRESET: logic_out = '1;
      default:     logic_out = '0;
    endcase
  end

endmodule

// File: rtl/alu4_ripple_slice.sv
module alu4_ripple_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       mode_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  alu_mode_e        mode_w;
  logic [WIDTH-1:0] adder_x;
  logic [WIDTH-1:0] adder_y;
  logic [WIDTH-1:0] adder_sum;
  logic [WIDTH:0]   carry_w;
  logic [WIDTH-1:0] logic_res;
  logic             arith_w;
  logic             carry_into_msb;
  logic             carry_from_msb;

  assign mode_w  = alu_mode_e'(mode_sel);
  assign arith_w = mode_is_arith(mode_w);

  alu_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .mode  (mode_w),
    .a_in  (op_a),
    .b_in  (op_b),
    .x_out (adder_x),
    .y_out (adder_y)
  );

  alu_ripple_adder #(.WIDTH(WIDTH)) u_add (
    .x     (adder_x),
    .y     (adder_y),
    .cin   (carry_in),
    .sum   (adder_sum),
    .carry (carry_w)
  );

  alu_bitwise_unit #(.WIDTH(WIDTH)) u_logic (
    .mode      (mode_w),
    .a_in      (op_a),
    .b_in      (op_b),
    .logic_out (logic_res)
  );

  assign carry_into_msb = carry_w[MSB];
  assign carry_from_msb = carry_w[WIDTH];

  assign result    = arith_w ? adder_sum : logic_res;
  assign carry_out = arith_w & carry_from_msb;
  assign overflow  = arith_w & (carry_into_msb ^ carry_from_msb);

endmodule

// File: rtl/alu4_ripple_slice_chk.sv
module alu4_ripple_slice_chk
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [2:0]       mode_sel,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             overflow,
  input logic [WIDTH-1:0] adder_x,
  input logic [WIDTH-1:0] adder_y
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] add_ref;
  assign add_ref = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    if (mode_sel == 3'd0)
      a_r2_clear_zero : assert (result == '0);
    if (mode_sel == 3'd7)
      a_r2_preset_ones : assert (result == '1);
    if (mode_sel == 3'd3)
      a_r3_add_sum : assert ({carry_out, result} == add_ref);
    if (mode_sel == 3'd2)
      a_r4_a_minus_b_operands : assert (adder_x == op_a && adder_y == ~op_b);
    if (mode_sel == 3'd1)
      a_r4_b_minus_a_operands : assert (adder_x == ~op_a && adder_y == op_b);
    if (mode_sel == 3'd1 || mode_sel == 3'd2 || mode_sel == 3'd3)
      a_r5_overflow_sign : assert (overflow ==
        sign_overflow(adder_x[MSB], adder_y[MSB], result[MSB]));
    if (mode_sel == 3'd0 || mode_sel >= 3'd4)
      a_r6_flags_low : assert (!carry_out && !overflow);
  end

endmodule

bind alu4_ripple_slice alu4_ripple_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .mode_sel  (mode_sel),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out),
  .overflow  (overflow),
  .adder_x   (adder_x),
  .adder_y   (adder_y)
);

// File: tb/alu4_ripple_slice_test.sv
module alu4_ripple_slice_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [3:0] a, b, f;
  logic [2:0] sel;
  logic       ci, co, ov;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  alu4_ripple_slice uut (
    .op_a(a), .op_b(b), .mode_sel(sel), .carry_in(ci),
    .result(f), .carry_out(co), .overflow(ov)
  );

  // 16-bit chain of four slices
  logic [15:0] ca, cb, cf;
  logic [2:0]  csel;
  logic [4:0]  cc;
  logic [3:0]  cov;
  assign cc[0] = ci;
  for (genvar k = 0; k < 4; k++) begin : g_chain
    alu4_ripple_slice u_sl (
      .op_a(ca[4*k +: 4]), .op_b(cb[4*k +: 4]), .mode_sel(csel), .carry_in(cc[k]),
      .result(cf[4*k +: 4]), .carry_out(cc[k+1]), .overflow(cov[k])
    );
  end

  // {sel, a, b, ci, f, co, ov}
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {3'd3, 4'h3, 4'h4, 1'b0, 4'h7, 1'b0, 1'b0},
    {3'd3, 4'h7, 4'h1, 1'b0, 4'h8, 1'b0, 1'b1},
    {3'd3, 4'hF, 4'h1, 1'b0, 4'h0, 1'b1, 1'b0},
    {3'd3, 4'h8, 4'h8, 1'b0, 4'h0, 1'b1, 1'b1},
    {3'd3, 4'hF, 4'hF, 1'b1, 4'hF, 1'b1, 1'b0},
    {3'd3, 4'h0, 4'h0, 1'b1, 4'h1, 1'b0, 1'b0},
    {3'd2, 4'h5, 4'h3, 1'b1, 4'h2, 1'b1, 1'b0},
    {3'd2, 4'h3, 4'h5, 1'b1, 4'hE, 1'b0, 1'b0},
    {3'd2, 4'h8, 4'h1, 1'b1, 4'h7, 1'b1, 1'b1},
    {3'd2, 4'h5, 4'h3, 1'b0, 4'h1, 1'b1, 1'b0},
    {3'd1, 4'h3, 4'h5, 1'b1, 4'h2, 1'b1, 1'b0},
    {3'd1, 4'h1, 4'h8, 1'b1, 4'h7, 1'b1, 1'b1},
    {3'd4, 4'hA, 4'h6, 1'b1, 4'hC, 1'b0, 1'b0},
    {3'd5, 4'hA, 4'h5, 1'b1, 4'hF, 1'b0, 1'b0},
    {3'd6, 4'hC, 4'hA, 1'b1, 4'h8, 1'b0, 1'b0},
    {3'd0, 4'hF, 4'hF, 1'b1, 4'h0, 1'b0, 1'b0},
    {3'd7, 4'h0, 4'h0, 1'b0, 4'hF, 1'b0, 1'b0}
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s sel=%0d a=%h b=%h ci=%b got=%h exp=%h",
               req, sel, a, b, ci, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] s, input logic [3:0] x, input logic [3:0] y,
                       input logic c);
    @(negedge clk);
    sel = s; a = x; b = y; ci = c;
    @(posedge clk);
    #1;
  endtask

  // Independent model: integer arithmetic with a signed range test.
  function automatic logic [5:0] model(input logic [2:0] s, input logic [3:0] x,
                                       input logic [3:0] y, input logic c);
    int ux, uy, tot, sx, sy, st;
    logic [3:0] r;
    case (s)
      3'd0: return 6'b0;
      3'd4: return {x ^ y, 2'b00};
      3'd5: return {x | y, 2'b00};
      3'd6: return {x & y, 2'b00};
      3'd7: return {4'hF, 2'b00};
      default: ;
    endcase
    ux = (s == 3'd1) ? 15 - int'(x) : int'(x);
    uy = (s == 3'd2) ? 15 - int'(y) : int'(y);
    tot = ux + uy + int'(c);
    r = tot[3:0];
    sx = (ux > 7) ? ux - 16 : ux;
    sy = (uy > 7) ? uy - 16 : uy;
    st = sx + sy + int'(c);
    return {r, tot > 15, (st > 7) || (st < -8)};
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [5:0] e;
    logic [16:0] tot;
    logic [15:0] ux, uy;
    logic exp_ov;
    ca = '0; cb = '0; csel = '0;

    // Initial state, all inputs low: clear mode, R8 outputs follow inputs only
    drive(3'd0, 4'h0, 4'h0, 1'b0);
    check("R2 init result", f, 0);
    check("R6 init flags", {co, ov}, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17:15], VEC[i][14:11], VEC[i][10:7], VEC[i][6]);
      check("R1 table result", f, VEC[i][5:2]);
      check("R3 R4 table carry", co, VEC[i][1]);
      check("R5 table overflow", ov, VEC[i][0]);
    end

    // Exhaustive sweep against model
    for (int s = 0; s < 8; s++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++) begin
            drive(s[2:0], x[3:0], y[3:0], c[0]);
            e = model(s[2:0], x[3:0], y[3:0], c[0]);
            if (s == 0 || s == 7) check("R2 const", f, e[5:2]);
            else check("R1 sweep result", f, e[5:2]);
            if (s == 0 || s >= 4) check("R6 flags low", {co, ov}, 0);
            else begin
              check("R4 sweep carry", co, e[1]);
              check("R5 sweep overflow", ov, e[0]);
            end
          end

    // R8: revisit a pattern after others, same answer
    drive(3'd3, 4'h9, 4'h9, 1'b1);
    check("R8 repeat a", {f, co, ov}, {4'h3, 1'b1, 1'b1});
    drive(3'd6, 4'hF, 4'h0, 1'b1);
    drive(3'd3, 4'h9, 4'h9, 1'b1);
    check("R8 repeat b", {f, co, ov}, {4'h3, 1'b1, 1'b1});

    // R7: 16-bit ripple chain
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      csel = (t % 3 == 0) ? 3'd3 : (t % 3 == 1) ? 3'd2 : 3'd1;
      ca = $urandom; cb = $urandom;
      if (t < 4) begin ca = 16'h7FFF; cb = 16'h0001 << t; end
      ci = (csel == 3'd3) ? t[3] : 1'b1;
      @(posedge clk);
      #1;
      ux = (csel == 3'd1) ? ~ca : ca;
      uy = (csel == 3'd2) ? ~cb : cb;
      tot = {1'b0, ux} + {1'b0, uy} + {16'b0, ci};
      exp_ov = (ux[15] == uy[15]) && (tot[15] != ux[15]);
      check("R7 chain result", cf, tot[15:0]);
      check("R7 chain carry", cc[4], tot[16]);
      check("R7 chain overflow", cov[3], exp_ov);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

endmodule